// File: doc/BRIEF.md
# Micro-op dispatch queue

This block sits between an instruction front end and an out-of-order back end. It holds decoded instructions in a circular slot buffer, where each instruction occupies as many slots as it has micro-ops. The count is capped at the buffer capacity, and a count of zero still uses one slot. On each clock the front end presents up to `LANES` instructions, each with its own valid bit, micro-op count and payload. The queue admits a leading run of them, in lane order. An instruction is admitted only when its slots fit into the space that was free at the start of the cycle, less the space already claimed by lower lanes in that cycle. An optional per-cycle admission limit (`MAX_IPC`, where zero means no limit) can also refuse it.

On the output side, one instruction per cycle leaves in arrival order over a valid/ready handshake, and the head is held while the consumer stalls. When an instruction leaves, all of its slots are returned at that clock edge. With `ZERO_LAT` set, an instruction admitted while the queue is empty is offered at the output in the same cycle, and it is never stored if it is taken. With `ZERO_LAT` clear, every instruction spends at least one cycle in the buffer. The `busy` output reports that at least one slot is occupied.

Top module: `uop_queue`

## Requirements
- R1: An instruction occupies min(count, DEPTH) slots, and a count of 0 occupies exactly 1 slot. An instruction whose count exceeds DEPTH is admitted into an empty queue and then fills it.
- R2: Lanes are considered from index 0 upward. Once a valid lane is refused, every higher lane is also refused in that cycle. `in_ready[i]` is high only for a valid lane that is admitted.
- R3: A lane is refused when its slots, added to the slots of lower lanes admitted in the same cycle, exceed the free slots registered at the start of the cycle. Slots released by a departure in the same cycle do not count toward this.
- R4: When MAX_IPC is nonzero, at most MAX_IPC lanes are admitted per cycle, and the first lane beyond the limit is refused. When MAX_IPC is 0, the count is unlimited.
- R5: Instructions leave strictly in admission order. `out_valid` is high whenever the buffer holds an instruction, and `out_payload` then carries the oldest payload.
- R6: While `out_valid` is high and `out_ready` is low, the next cycle shows `out_valid` high with an unchanged `out_payload`.
- R7: With ZERO_LAT=1 and an empty buffer, the lowest admitted lane is presented at the output in the same cycle. If `out_ready` is high it departs and uses no slots afterwards; otherwise it is stored as the head.
- R8: With ZERO_LAT=0, `out_valid` is low whenever the buffer is empty, even in a cycle that admits instructions.
- R9: On a departure, all slots of the departing instruction become free at that same clock edge.
- R10: `busy` is high exactly when at least one slot is occupied.
- R11: After reset, the buffer is empty, `busy` and `out_valid` are low, and the full capacity is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | LANES | Per-lane instruction offered |
| in_uops | input | LANES*UOP_W | Per-lane micro-op count, lane i at bits [i*UOP_W +: UOP_W] |
| in_payload | input | LANES*PAY_W | Per-lane payload, lane i at bits [i*PAY_W +: PAY_W] |
| in_ready | output | LANES | Per-lane admission this cycle |
| out_valid | output | 1 | Head instruction offered |
| out_ready | input | 1 | Consumer takes the head |
| out_payload | output | PAY_W | Payload of the offered instruction |
| busy | output | 1 | At least one slot occupied |

## Verification
The bench builds two copies with DEPTH=6 (not a power of two, so index wrap-around is exercised), three lanes and a 4-bit count field, so counts from 7 to 15 exercise the capacity cap. The first copy uses MAX_IPC=2 and ZERO_LAT=1, so that the admission limit and the same-cycle bypass both act. The second uses MAX_IPC=0 and ZERO_LAT=0, which brings the unlimited three-lane admission and the one-cycle delay within reach. Both copies see the same input lanes with separate consumer stalls, so the full and nearly-full cases occur under both configurations.

// File: rtl/uq_pkg.sv
package uq_pkg;

    // Where the output stage takes its instruction from
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_RING   = 2'd1,
        SRC_BYPASS = 2'd2
    } out_src_e;

    // Slots taken by one instruction: count capped at capacity, minimum one
    function automatic int unsigned norm_slots(int unsigned cnt, int unsigned depth);
        if (cnt == 0)
            return 1;
        else if (cnt > depth)
            return depth;
        else
            return cnt;
    endfunction

    // Single-step wrap of a ring position; the caller keeps a < 2*depth
    function automatic int unsigned wrap_idx(int unsigned a, int unsigned depth);
        return (a >= depth) ? a - depth : a;
    endfunction

endpackage

// File: rtl/uq_admit.sv
module uq_admit
    import uq_pkg::*;
#(
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned LANES   = 4,
    parameter int unsigned UOP_W   = 4,
    parameter int unsigned MAX_IPC = 2,
    parameter int unsigned CW      = $clog2(DEPTH + 1)
) (
    input  logic [LANES-1:0]            lane_vld,
    input  logic [LANES-1:0][UOP_W-1:0] lane_uops,
    input  logic [CW-1:0]               free_slots,
    output logic [LANES-1:0]            lane_acc,
    output logic [LANES-1:0]            lane_first,
    output logic [LANES-1:0][CW-1:0]    lane_slots
);

    localparam int unsigned TW = $clog2(LANES + 1);

    logic [TW-1:0] n_taken;
    logic [CW:0]   claimed;
    logic          blocked;
    logic          cap_ok;

    // Walk lanes in order; the first refusal closes the rest of the cycle
    always_comb begin
        n_taken    = '0;
        claimed    = '0;
        blocked    = 1'b0;
        cap_ok     = 1'b0;
        lane_acc   = '0;
        lane_first = '0;
        for (int i = 0; i < LANES; i++) begin
            lane_slots[i] = CW'(norm_slots(32'(lane_uops[i]), DEPTH));
            cap_ok = (MAX_IPC == 0) || (32'(n_taken) < MAX_IPC);
            if (lane_vld[i] && !blocked) begin
                if (cap_ok &&
                    ((claimed + (CW+1)'(lane_slots[i])) <= (CW+1)'(free_slots))) begin
                    lane_acc[i] = 1'b1;
                    if (n_taken == '0)
                        lane_first[i] = 1'b1;
                    n_taken = n_taken + 1'b1;
                    claimed = claimed + (CW+1)'(lane_slots[i]);
                end else begin
                    blocked = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/uq_ring.sv
module uq_ring
    import uq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LANES = 4,
    parameter int unsigned PAY_W = 16,
    parameter int unsigned CW    = $clog2(DEPTH + 1),
    parameter int unsigned IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [LANES-1:0]            store_en,
    input  logic [LANES-1:0][CW-1:0]    lane_slots,
    input  logic [LANES-1:0][PAY_W-1:0] lane_pay,
    input  logic                        pop,
    output logic [PAY_W-1:0]            head_pay,
    output logic [CW-1:0]               used_slots
);

    // One record per instruction, kept at the first slot it occupies
    logic [PAY_W-1:0] pay_mem [DEPTH];
    logic [CW-1:0]    len_mem [DEPTH];

    logic [IW-1:0]             wr_q;
    logic [IW-1:0]             rd_q;
    logic [CW-1:0]             used_q;
    logic [LANES-1:0][IW-1:0]  wpos;
    logic [CW:0]               store_total;
    logic [CW:0]               run;
    logic [CW-1:0]             head_len;

    always_comb begin
        run = '0;
        for (int i = 0; i < LANES; i++) begin
            wpos[i] = IW'(wrap_idx(32'(wr_q) + 32'(run), DEPTH));
            if (store_en[i])
                run = run + (CW+1)'(lane_slots[i]);
        end
        store_total = run;
    end

    assign head_len   = len_mem[rd_q];
    assign head_pay   = pay_mem[rd_q];
    assign used_slots = used_q;

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (!rst && store_en[i]) begin
                pay_mem[wpos[i]] <= lane_pay[i];
                len_mem[wpos[i]] <= lane_slots[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= '0;
            rd_q   <= '0;
            used_q <= '0;
        end else begin
            wr_q <= IW'(wrap_idx(32'(wr_q) + 32'(store_total), DEPTH));
            if (pop)
                rd_q <= IW'(wrap_idx(32'(rd_q) + 32'(head_len), DEPTH));
            used_q <= CW'(32'(used_q) + 32'(store_total)
                          - (pop ? 32'(head_len) : 32'd0));
        end
    end

endmodule

// File: rtl/uq_out.sv
module uq_out
    import uq_pkg::*;
#(
    parameter int unsigned LANES    = 4,
    parameter int unsigned PAY_W    = 16,
    parameter bit          ZERO_LAT = 1'b1
) (
    input  logic                        ring_busy,
    input  logic [PAY_W-1:0]            head_pay,
    input  logic [LANES-1:0]            lane_first,
    input  logic [LANES-1:0][PAY_W-1:0] lane_pay,
    input  logic                        out_ready,
    output logic                        out_valid,
    output logic [PAY_W-1:0]            out_payload,
    output logic                        pop,
    output logic                        byp_take
);

    out_src_e         src;
    logic [PAY_W-1:0] byp_pay;

    generate
        if (ZERO_LAT) begin : g_bypass
            always_comb begin
                byp_pay = '0;
                for (int i = 0; i < LANES; i++)
                    if (lane_first[i])
                        byp_pay = byp_pay | lane_pay[i];
            end
            always_comb begin
                if (ring_busy)
                    src = SRC_RING;
                else if (|lane_first)
                    src = SRC_BYPASS;
                else
                    src = SRC_NONE;
            end
        end else begin : g_delay
            logic unused_lanes;
            assign unused_lanes = ^{lane_first, lane_pay};
            assign byp_pay = '0;
            always_comb src = ring_busy ? SRC_RING : SRC_NONE;
        end
    endgenerate

    assign out_valid   = (src != SRC_NONE);
    assign out_payload = (src == SRC_RING) ? head_pay : byp_pay;
    assign pop         = (src == SRC_RING) && out_ready;
    assign byp_take    = (src == SRC_BYPASS) && out_ready;

endmodule

// File: rtl/uop_queue.sv
module uop_queue
    import uq_pkg::*;
#(
    parameter int unsigned DEPTH    = 8,
    parameter int unsigned LANES    = 4,
    parameter int unsigned PAY_W    = 16,
    parameter int unsigned UOP_W    = 4,
    parameter int unsigned MAX_IPC  = 2,
    parameter bit          ZERO_LAT = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LANES-1:0]         in_valid,
    input  logic [LANES*UOP_W-1:0]   in_uops,
    input  logic [LANES*PAY_W-1:0]   in_payload,
    output logic [LANES-1:0]         in_ready,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [PAY_W-1:0]         out_payload,
    output logic                     busy
);

    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LANES-1:0][UOP_W-1:0] uops_v;
    logic [LANES-1:0][PAY_W-1:0] pay_v;
    logic [LANES-1:0][CW-1:0]    lane_slots;
    logic [LANES-1:0]            lane_acc;
    logic [LANES-1:0]            lane_first;
    logic [LANES-1:0]            store_en;
    logic [CW-1:0]               used_cnt;
    logic [CW-1:0]               free_cnt;
    logic [PAY_W-1:0]            head_pay;
    logic                        pop;
    logic                        byp_take;

    assign uops_v   = in_uops;
    assign pay_v    = in_payload;
    assign free_cnt = CW'(DEPTH) - used_cnt;
    assign busy     = (used_cnt != '0);
    assign in_ready = lane_acc;
    // A bypassed instruction that leaves at once never enters the ring
    assign store_en = lane_acc & ~(lane_first & {LANES{byp_take}});

    uq_admit #(
        .DEPTH(DEPTH), .LANES(LANES), .UOP_W(UOP_W),
        .MAX_IPC(MAX_IPC), .CW(CW)
    ) u_admit (
        .lane_vld   (in_valid),
        .lane_uops  (uops_v),
        .free_slots (free_cnt),
        .lane_acc   (lane_acc),
        .lane_first (lane_first),
        .lane_slots (lane_slots)
    );

    uq_ring #(
        .DEPTH(DEPTH), .LANES(LANES), .PAY_W(PAY_W), .CW(CW), .IW(IW)
    ) u_ring (
        .clk        (clk),
        .rst        (rst),
        .store_en   (store_en),
        .lane_slots (lane_slots),
        .lane_pay   (pay_v),
        .pop        (pop),
        .head_pay   (head_pay),
        .used_slots (used_cnt)
    );

    uq_out #(
        .LANES(LANES), .PAY_W(PAY_W), .ZERO_LAT(ZERO_LAT)
    ) u_out (
        .ring_busy   (busy),
        .head_pay    (head_pay),
        .lane_first  (lane_first),
        .lane_pay    (pay_v),
        .out_ready   (out_ready),
        .out_valid   (out_valid),
        .out_payload (out_payload),
        .pop         (pop),
        .byp_take    (byp_take)
    );

endmodule

// File: rtl/uop_queue_chk.sv
module uop_queue_chk #(
    parameter int unsigned DEPTH    = 8,
    parameter int unsigned LANES    = 4,
    parameter int unsigned PAY_W    = 16,
    parameter int unsigned MAX_IPC  = 2,
    parameter bit          ZERO_LAT = 1'b1,
    parameter int unsigned CW       = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [LANES-1:0] in_valid,
    input logic [LANES-1:0] in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PAY_W-1:0] out_payload,
    input logic             busy,
    input logic [CW-1:0]    used_cnt
);

    // R2
    ready_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready & ~in_valid) == '0);

    // R6
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_payload)));

    // R1
    slot_bound_chk: assert property (@(posedge clk) disable iff (rst)
        used_cnt <= CW'(DEPTH));

    // R11
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!busy && used_cnt == '0));

    // R5
    busy_offers_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> out_valid);

    generate
        if (MAX_IPC != 0) begin : g_cap
            // R4
            ipc_cap_chk: assert property (@(posedge clk) disable iff (rst)
                $countones(in_ready) <= MAX_IPC);
        end
        if (!ZERO_LAT) begin : g_delay
            // R8
            no_early_out_chk: assert property (@(posedge clk) disable iff (rst)
                !busy |-> !out_valid);
        end
    endgenerate

endmodule

bind uop_queue uop_queue_chk #(
    .DEPTH(DEPTH), .LANES(LANES), .PAY_W(PAY_W),
    .MAX_IPC(MAX_IPC), .ZERO_LAT(ZERO_LAT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_payload(out_payload),
    .busy       (busy),
    .used_cnt   (used_cnt)
);

// File: tb/sim_uop_queue.sv
`timescale 1ns/1ps
module sim_uop_queue;

    localparam int D  = 6;
    localparam int L  = 3;
    localparam int PW = 8;
    localparam int UW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [L-1:0]  tv;
    logic [UW-1:0] tu [L];
    logic [PW-1:0] tp [L];
    logic          rdy0, rdy1;

    logic [L*UW-1:0] in_uops;
    logic [L*PW-1:0] in_pay;
    assign in_uops = {tu[2], tu[1], tu[0]};
    assign in_pay  = {tp[2], tp[1], tp[0]};

    logic [L-1:0]  ir0, ir1;
    logic          ov0, ov1, bz0, bz1;
    logic [PW-1:0] op0, op1;

    uop_queue #(.DEPTH(D), .LANES(L), .PAY_W(PW), .UOP_W(UW),
                .MAX_IPC(2), .ZERO_LAT(1'b1)) u0 (
        .clk(clk), .rst(rst), .in_valid(tv), .in_uops(in_uops),
        .in_payload(in_pay), .in_ready(ir0), .out_valid(ov0),
        .out_ready(rdy0), .out_payload(op0), .busy(bz0));

    uop_queue #(.DEPTH(D), .LANES(L), .PAY_W(PW), .UOP_W(UW),
                .MAX_IPC(0), .ZERO_LAT(1'b0)) u1 (
        .clk(clk), .rst(rst), .in_valid(tv), .in_uops(in_uops),
        .in_payload(in_pay), .in_ready(ir1), .out_valid(ov1),
        .out_ready(rdy1), .out_payload(op1), .busy(bz1));

    // Bench model: per-copy queue of (payload, slots)
    int qpay [2][64];
    int qlen [2][64];
    int qhead[2];
    int qcnt [2];
    int mused[2];
    int n_chk  = 0;
    int n_fail = 0;
    int pay_seq = 1;
    bit done = 1'b0;

    function automatic int nslots(int c);
        if (c == 0) return 1;
        if (c > D)  return D;
        return c;
    endfunction

    task automatic chk(int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic drive(logic [L-1:0] v, int a, int b, int c, logic r0, logic r1);
        tv = v;
        tu[0] = UW'(a); tu[1] = UW'(b); tu[2] = UW'(c);
        for (int i = 0; i < L; i++) begin
            tp[i] = PW'(pay_seq);
            pay_seq++;
        end
        rdy0 = r0;
        rdy1 = r1;
    endtask

    // Inputs are set just after a falling edge; compare, advance model, wait
    task automatic step(string tag);
        #1;
        for (int k = 0; k < 2; k++) begin
            int cap;
            bit zl;
            int free_s;
            int taken;
            int used_now;
            int first;
            int ov;
            int od;
            bit byp;
            bit fire;
            bit blocked;
            logic [L-1:0] acc;
            cap = (k == 0) ? 2 : 0;
            zl  = (k == 0);
            free_s = D - mused[k];
            taken = 0; used_now = 0; first = -1; ov = 0; od = 0;
            byp = 1'b0; blocked = 1'b0; acc = '0;
            for (int i = 0; i < L; i++) begin
                if (tv[i] && !blocked) begin
                    int s;
                    s = nslots(int'(tu[i]));
                    if ((cap == 0 || taken < cap) && used_now + s <= free_s) begin
                        acc[i] = 1'b1;
                        if (first < 0) first = i;
                        taken++;
                        used_now += s;
                    end else begin
                        blocked = 1'b1;
                    end
                end
            end
            if (qcnt[k] > 0) begin
                ov = 1; od = qpay[k][qhead[k]];
            end else if (zl && first >= 0) begin
                ov = 1; od = int'(tp[first]); byp = 1'b1;
            end
            chk(int'(k == 0 ? ir0 : ir1), int'(acc), $sformatf("%s u%0d in_ready", tag, k));
            chk(int'(k == 0 ? ov0 : ov1), ov, $sformatf("%s u%0d out_valid", tag, k));
            chk(int'(k == 0 ? bz0 : bz1), int'(mused[k] != 0), $sformatf("%s u%0d busy", tag, k));
            if (ov == 1)
                chk(int'(k == 0 ? op0 : op1), od, $sformatf("%s u%0d out_payload", tag, k));
            fire = (ov == 1) && (k == 0 ? rdy0 : rdy1);
            if (fire && !byp) begin
                mused[k] -= qlen[k][qhead[k]];
                qhead[k] = (qhead[k] + 1) % 64;
                qcnt[k]--;
            end
            for (int i = 0; i < L; i++) begin
                if (acc[i] && !(fire && byp && i == first)) begin
                    int p;
                    p = (qhead[k] + qcnt[k]) % 64;
                    qpay[k][p] = int'(tp[i]);
                    qlen[k][p] = nslots(int'(tu[i]));
                    qcnt[k]++;
                    mused[k] += qlen[k][p];
                end
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        drive('0, 0, 0, 0, 1'b0, 1'b0);
        for (int k = 0; k < 2; k++) begin
            qhead[k] = 0; qcnt[k] = 0; mused[k] = 0;
        end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        drive('0, 0, 0, 0, 1'b0, 1'b0);
        step("R11 reset state");
        // Zero count takes one slot; u0 offers it at once, u1 does not
        drive(3'b001, 0, 0, 0, 1'b0, 1'b0);
        step("R1 R7 R8 zero count");
        // Capped count needs 6 slots but only 5 are free; head held
        drive(3'b001, 15, 0, 0, 1'b0, 1'b0);
        step("R3 R6 refuse and hold");
        // Departure this cycle does not widen the snapshot
        drive(3'b001, 15, 0, 0, 1'b1, 1'b1);
        step("R3 R9 R5 snapshot");
        drive(3'b001, 15, 0, 0, 1'b0, 1'b0);
        step("R1 cap fills queue");
        drive(3'b111, 1, 1, 1, 1'b0, 1'b0);
        step("R10 R3 full queue");
        drive('0, 0, 0, 0, 1'b1, 1'b1);
        step("R9 whole release");
        drive(3'b111, 1, 1, 1, 1'b1, 1'b1);
        step("R4 R2 R7 rate limit");
        drive(3'b111, 2, 0, 9, 1'b0, 1'b0);
        step("R2 R3 lane order");
        for (int n = 0; n < 8; n++) begin
            drive('0, 0, 0, 0, 1'b1, 1'b1);
            step("R5 R10 drain");
        end

        void'($urandom(32'd20240611));
        for (int n = 0; n < 5000; n++) begin
            int a, b, c, r;
            r = int'($urandom % 8); a = (r < 6) ? r % 3 : int'($urandom % 16);
            r = int'($urandom % 8); b = (r < 6) ? r % 3 : int'($urandom % 16);
            r = int'($urandom % 8); c = (r < 6) ? r % 3 : int'($urandom % 16);
            drive(L'($urandom), a, b, c,
                  ($urandom % 4) != 0, ($urandom % 3) != 0);
            step("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule